// File: doc/BRIEF.md
# Ringer tone sequence generator

This block produces the ringing melody of a telephone ringer from a slow system clock (32 kHz by default). A melody is a fixed list of intervals. Each interval plays one of seven tones or stays silent for its whole length. A two-bit melody select picks one of four built-in melodies, and a two-bit rate select picks one of four interval lengths. While the ring enable is high the block steps through the melody and loops it. It presents the current tone code, a square wave at the tone's pitch and a two-bit swell level. A later output stage uses the swell level to raise the loudness.

The swell level climbs by one step each time the last interval of a melody completes, and it stops at 3. It is kept while the ringer sits idle between bursts, and only the reset input clears it. When the enable falls, the interval that is playing runs to its end. The block then parks at the start of the melody and goes silent. A select that is left unconnected reads as 0 at the chip boundary, so code 0 on either select is the default melody and rate.

Top module: `ring_seq_top`

## Requirements
- R1: After reset, and while the block is idle, `tone_code`, `tone_wave` and `swell_lvl` are all 0.
- R2: Tone codes are 0 for silence and 1..7 for 553, 600, 667, 800, 1000, 1067 and 1333 Hz. For `seq_sel` = s and interval index i, the code is: s=0: i mod 8. s=1: 7 − (i mod 8). s=2: 0 for odd i, 7 when i mod 4 = 0, and 4 otherwise. s=3: i mod 3 gives 5, 3, 0 for remainders 0, 1, 2.
- R3: A melody has 16 intervals when `seq_sel` is 0 or 2 and 15 when it is 1 or 3. After the last interval, playback continues at index 0.
- R4: One interval lasts `INTV_UNIT` × m clock cycles, where m is 2, 3, 4 or 6 for `rate_sel` 0, 1, 2 or 3.
- R5: In the j-th cycle of an interval (j from 0), `tone_wave` = 1 exactly when the code is not 0 and floor(j / h) is odd. Here h = round(`CLK_HZ` / (2·f)) for the tone's frequency f. A silent interval keeps `tone_wave` at 0.
- R6: When the block is idle and `ring_en` is sampled high at a clock edge, interval 0 begins in the cycle after that edge.
- R7: If `ring_en` is low at the edge that ends an interval, the block becomes idle with index 0, and `tone_code` and `tone_wave` read 0. A low level of `ring_en` that does not span an interval end has no effect.
- R8: Completing the last interval of a melody raises `swell_lvl` by 1, saturating at 3. This holds even when the same edge stops playback. `swell_lvl` never changes in any other way except by reset.
- R9: `swell_lvl` holds its value through any idle time. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (32 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_en | input | 1 | Ring enable; high plays, low stops at the next interval end |
| seq_sel | input | 2 | Melody select |
| rate_sel | input | 2 | Interval length select |
| tone_code | output | 3 | Code of the interval now playing, 0 when idle |
| tone_wave | output | 1 | Square wave at the current tone's pitch |
| swell_lvl | output | 2 | Loudness step, 0 to 3 |

## Verification
Two functions of this block can act at the same clock edge: the swell step and the stop. Both happen at the edge that closes a melody's last interval, when `ring_en` has already dropped. The bench lets the melody run into its final interval and lowers the enable part-way through that interval. It then checks, cycle by cycle against an arithmetic model, that the swell rises to 1 on the same edge that the tone code falls to 0. The same model also follows a low pulse on the enable that is too short to reach an interval end, and confirms it changes nothing.

// File: rtl/ring_pkg.sv
`timescale 1ns/1ps
package ring_pkg;

  localparam int unsigned STEP_W = 4;

  typedef logic [2:0]        tone_code_t;
  typedef logic [STEP_W-1:0] step_t;

  // pitch in Hz for each tone code; code 0 is silence
  function automatic int unsigned tone_hz(input tone_code_t c);
    case (c)
      3'd1:    return 553;
      3'd2:    return 600;
      3'd3:    return 667;
      3'd4:    return 800;
      3'd5:    return 1000;
      3'd6:    return 1067;
      3'd7:    return 1333;
      default: return 0;
    endcase
  endfunction

  // half period in clock cycles, rounded to nearest
  function automatic int unsigned half_ticks(input int unsigned clk_hz, input tone_code_t c);
    int unsigned f;
    f = tone_hz(c);
    if (f == 0) f = 553;
    return (clk_hz + f) / (2 * f);
  endfunction

  function automatic int unsigned rate_mult(input logic [1:0] r);
    case (r)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction

  function automatic step_t seq_last(input logic [1:0] s);
    return s[0] ? step_t'(14) : step_t'(15);
  endfunction

  function automatic tone_code_t seq_code(input logic [1:0] s, input step_t i);
    logic [3:0] m3;
    m3 = i % 4'd3;
    case (s)
      2'd0: return i[2:0];
      2'd1: return 3'd7 - i[2:0];
      2'd2: begin
        if (i[0])      return 3'd0;
        else if (i[1]) return 3'd4;
        else           return 3'd7;
      end
      default: begin
        case (m3)
          4'd0:    return 3'd5;
          4'd1:    return 3'd3;
          default: return 3'd0;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/ring_rst_sync.sv
`timescale 1ns/1ps
module ring_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign srst_n = q2;
endmodule

// File: rtl/ring_seq_rom.sv
`timescale 1ns/1ps
module ring_seq_rom
  import ring_pkg::*;
(
  input  logic [1:0] seq_sel,
  input  step_t      step,
  output tone_code_t code
);
  always_comb begin
    code = seq_code(seq_sel, step);
  end
endmodule

// File: rtl/ring_interval_ctl.sv
`timescale 1ns/1ps
module ring_interval_ctl
  import ring_pkg::*;
#(
  parameter int unsigned INTV_UNIT = 4096,
  parameter int unsigned TICK_W    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_en,
  input  logic [1:0]        seq_sel,
  input  logic [1:0]        rate_sel,
  output logic              active,
  output step_t             step,
  output logic [TICK_W-1:0] tick,
  output logic [1:0]        swell,
  output logic              restart
);
  logic              active_q, active_d;
  step_t             step_q, step_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [1:0]        swell_q, swell_d;
  logic              last_tick, last_step;

  always_comb begin
    last_tick = (tick_q == TICK_W'(INTV_UNIT * rate_mult(rate_sel) - 1));
    last_step = (step_q >= seq_last(seq_sel));
    active_d  = active_q;
    step_d    = step_q;
    tick_d    = tick_q;
    swell_d   = swell_q;
    restart   = 1'b0;
    if (!active_q) begin
      if (ring_en) begin
        active_d = 1'b1;
        step_d   = '0;
        tick_d   = '0;
        restart  = 1'b1;
      end
    end else if (last_tick) begin
      tick_d  = '0;
      restart = 1'b1;
      if (last_step) begin
        step_d = '0;
        if (swell_q != 2'd3) swell_d = swell_q + 2'd1;
      end else begin
        step_d = step_q + step_t'(1);
      end
      if (!ring_en) begin
        active_d = 1'b0;
        step_d   = '0;
      end
    end else begin
      tick_d = tick_q + TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
      tick_q   <= '0;
      swell_q  <= '0;
    end else begin
      active_q <= active_d;
      step_q   <= step_d;
      tick_q   <= tick_d;
      swell_q  <= swell_d;
    end
  end

  assign active = active_q;
  assign step   = step_q;
  assign tick   = tick_q;
  assign swell  = swell_q;
endmodule

// File: rtl/ring_tone_div.sv
`timescale 1ns/1ps
module ring_tone_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             wave
);
  logic [DIV_W-1:0] div_q, div_d;
  logic             wave_q, wave_d;

  always_comb begin
    div_d  = div_q;
    wave_d = wave_q;
    if (restart) begin
      div_d  = '0;
      wave_d = 1'b0;
    end else if (run) begin
      if (div_q == half - DIV_W'(1)) begin
        div_d  = '0;
        wave_d = ~wave_q;
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q;
endmodule

// File: rtl/ring_seq_top.sv
`timescale 1ns/1ps
module ring_seq_top
  import ring_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 32000,
  parameter int unsigned INTV_UNIT = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ring_en,
  input  logic [1:0] seq_sel,
  input  logic [1:0] rate_sel,
  output logic [2:0] tone_code,
  output logic       tone_wave,
  output logic [1:0] swell_lvl
);
  localparam int unsigned TICK_W = $clog2(INTV_UNIT * 6);
  localparam int unsigned DIV_W  = $clog2(half_ticks(CLK_HZ, 3'd1) + 1);

  logic              srst_n;
  logic              active;
  step_t             step;
  logic [TICK_W-1:0] tick;
  logic [1:0]        swell;
  logic              restart;
  tone_code_t        code;
  logic [DIV_W-1:0]  half;
  logic              sq;

  ring_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ring_interval_ctl #(
    .INTV_UNIT (INTV_UNIT),
    .TICK_W    (TICK_W)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (srst_n),
    .ring_en  (ring_en),
    .seq_sel  (seq_sel),
    .rate_sel (rate_sel),
    .active   (active),
    .step     (step),
    .tick     (tick),
    .swell    (swell),
    .restart  (restart)
  );

  ring_seq_rom u_rom (
    .seq_sel (seq_sel),
    .step    (step),
    .code    (code)
  );

  assign half = DIV_W'(half_ticks(CLK_HZ, code));

  ring_tone_div #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (srst_n),
    .restart (restart),
    .run     (active),
    .half    (half),
    .wave    (sq)
  );

  assign tone_code = active ? code : 3'd0;
  assign tone_wave = active && (code != 3'd0) && sq;
  assign swell_lvl = swell;
endmodule

// File: rtl/ring_seq_chk.sv
`timescale 1ns/1ps
module ring_seq_chk #(
  parameter int unsigned INTV_UNIT = 4096,
  parameter int unsigned TICK_W    = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic [3:0]        step,
  input logic [TICK_W-1:0] tick,
  input logic [1:0]        swell,
  input logic [1:0]        seq_sel,
  input logic [1:0]        rate_sel,
  input logic [2:0]        tone_code,
  input logic              tone_wave
);
  function automatic logic [TICK_W-1:0] end_tick(input logic [1:0] r);
    int unsigned m;
    case (r)
      2'd0:    m = 2;
      2'd1:    m = 3;
      2'd2:    m = 4;
      default: m = 6;
    endcase
    return TICK_W'(INTV_UNIT * m - 1);
  endfunction

  a_r8_swell_step: assert property (@(posedge clk) disable iff (!rst_n)
    (swell != $past(swell)) |-> (swell == $past(swell) + 2'd1));

  a_r9_swell_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |-> $stable(swell));

  a_r5_pause_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_code == 3'd0) |-> !tone_wave);

  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= (seq_sel[0] ? 4'd14 : 4'd15));

  a_r4_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= end_tick(rate_sel));

  a_r7_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(tick) == end_tick($past(rate_sel))));

  a_r6_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (step == 4'd0 && tick == '0));
endmodule

bind ring_seq_top ring_seq_chk #(
  .INTV_UNIT (INTV_UNIT),
  .TICK_W    (TICK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .active    (active),
  .step      (step),
  .tick      (tick),
  .swell     (swell),
  .seq_sel   (seq_sel),
  .rate_sel  (rate_sel),
  .tone_code (tone_code),
  .tone_wave (tone_wave)
);

// File: tb/tb_ring_seq_top.sv
`timescale 1ns/1ps
module tb_ring_seq_top;
  localparam int CLK_HZ = 32000;
  localparam int UNIT   = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [1:0] ts, rr;
  logic [2:0] tone_code;
  logic       tone_wave;
  logic [1:0] swell_lvl;

  always #2 clk = ~clk;

  ring_seq_top #(.CLK_HZ(CLK_HZ), .INTV_UNIT(UNIT)) dut (
    .clk(clk), .rst_n(rst_n), .ring_en(en), .seq_sel(ts), .rate_sel(rr),
    .tone_code(tone_code), .tone_wave(tone_wave), .swell_lvl(swell_lvl)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R1";

  // expected values from the requirements
  function automatic int e_code(int s, int i);
    case (s)
      0: return i % 8;
      1: return 7 - (i % 8);
      2: return (i % 2 == 1) ? 0 : ((i % 4 == 0) ? 7 : 4);
      default: return (i % 3 == 0) ? 5 : ((i % 3 == 1) ? 3 : 0);
    endcase
  endfunction

  function automatic int e_seqlen(int s);
    return (s % 2 == 1) ? 15 : 16;
  endfunction

  function automatic int e_ivl(int r);
    case (r)
      0: return UNIT * 2;
      1: return UNIT * 3;
      2: return UNIT * 4;
      default: return UNIT * 6;
    endcase
  endfunction

  function automatic int e_half(int c);
    int f;
    case (c)
      1: f = 553;  2: f = 600;  3: f = 667;  4: f = 800;
      5: f = 1000; 6: f = 1067; default: f = 1333;
    endcase
    return (CLK_HZ + f) / (2 * f);
  endfunction

  // arithmetic reference of the playback position
  bit m_act;
  int m_step, m_tick, m_swell;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_step = 0; m_tick = 0; m_swell = 0;
    end else if (!m_act) begin
      if (en) begin m_act = 1; m_step = 0; m_tick = 0; end
    end else if (m_tick == e_ivl(rr) - 1) begin
      m_tick = 0;
      if (m_step == e_seqlen(ts) - 1) begin
        m_step = 0;
        if (m_swell < 3) m_swell = m_swell + 1;
      end else m_step = m_step + 1;
      if (!en) begin m_act = 0; m_step = 0; end
    end else m_tick = m_tick + 1;
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    int ec, ew;
    @(negedge clk);
    ec = m_act ? e_code(ts, m_step) : 0;
    ew = (m_act && ec != 0 && ((m_tick / e_half(ec)) % 2 == 1)) ? 1 : 0;
    chk("R2 tone_code", int'(tone_code), ec);
    chk("R5 tone_wave", int'(tone_wave), ew);
    chk("R8 swell_lvl", int'(swell_lvl), m_swell);
  endtask

  task automatic run(int n);
    repeat (n) cyc();
  endtask

  task automatic do_reset();
    tag = "R1";
    en = 0;
    rst_n = 0;
    run(2);
    rst_n = 1;
    run(4);
    chk("R1 code idle", int'(tone_code), 0);
    chk("R1 wave idle", int'(tone_wave), 0);
    chk("R1 swell cleared", int'(swell_lvl), 0);
  endtask

  initial begin
    rst_n = 0; en = 0; ts = 0; rr = 0;
    do_reset();

    // R3 R4 R6: every melody at every rate, one full pass plus one interval
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        do_reset();
        tag = "R3 R4 R6 sweep";
        ts = 2'(s); rr = 2'(r);
        run(2);
        en = 1;
        run(e_seqlen(s) * e_ivl(r) + e_ivl(r) + 5);
        en = 0;
        run(e_ivl(r) + 5);
        chk("R3 swell after one pass", int'(swell_lvl), 1);
        chk("R7 idle after stop", int'(tone_code), 0);
      end
    end

    // R8: saturation over five passes
    do_reset();
    tag = "R8 saturate";
    ts = 2'd1; rr = 2'd0;
    en = 1;
    run(5 * 15 * 32 + 10);
    chk("R8 swell saturated", int'(swell_lvl), 3);

    // R7 R9 R6: short low pulse, long idle, restart
    do_reset();
    tag = "R7 R9 enable";
    ts = 2'd2; rr = 2'd0;
    en = 1;
    run(16 * 32 + 40);
    en = 0;
    run(5);
    en = 1;
    run(40);
    en = 0;
    run(200);
    chk("R9 swell held idle", int'(swell_lvl), 1);
    chk("R7 code after stop", int'(tone_code), 0);
    tag = "R6 restart";
    en = 1;
    run(2);
    chk("R6 restart at index 0", int'(tone_code), 7);
    run(100);

    // R8 R7: stop edge and swell step on the same edge
    do_reset();
    tag = "R8 R7 collision";
    ts = 2'd3; rr = 2'd1;
    en = 1;
    run(14 * 48 + 10);
    en = 0;
    run(60);
    chk("R8 swell on final stop", int'(swell_lvl), 1);
    chk("R7 idle after final stop", int'(tone_code), 0);
    run(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule